// File: doc/BRIEF.md
# Single-Sector LBA28 Programmed-I/O Write Sequencer

This block sits on the host side of a parallel disk interface. It turns one write request into the complete series of bus cycles that a drive needs to store one 512-byte sector with 28-bit logical block addressing. A request carries a drive select bit and a block address. The sequencer first checks the address. It then loads the address and count registers of the drive and writes the write-sectors command. It reads the status register until the drive asks for data, and then moves 256 sixteen-bit words from a first-word-fall-through FIFO onto the data register. Finally it issues a cache-flush command and waits for the drive to go idle before it reports the result.

The bus side has a 3-bit register offset, a 16-bit write value, separate write and read strobes that are high for one cycle, and an 8-bit status input. The drive returns the status in the cycle after the read strobe. Command bytes go to offset 7 and data words go to offset 0. Status is also read from offset 7. Completion is a one-cycle `done` pulse. The error flag, the timeout flag and the last status byte read stay on the outputs until the next completion. An upper limit on status reads per wait, set at an input, keeps a silent drive from stalling the sequencer forever.

Top module: `ata_wr_seq`

## Requirements
- R1: The first bus write goes to offset 6 with the value {1,1,1,drive,lba[27:24]}: bits 7, 6 and 5 are set, bit 4 is the drive select and bits 3..0 are address bits 27..24.
- R2: An accepted request writes, in this order and in consecutive cycles: offset 6 (drive/head), offset 2 with 0x01, offset 3 with lba[7:0], offset 4 with lba[15:8], offset 5 with lba[23:16], and offset 7 with the write command 0x30. Byte values are on bits 7..0 and bits 15..8 are zero.
- R3: A request with an address above 0x0FFFFFFF (any of bits 31..28 set) makes no bus write and no bus read. The cycle after acceptance shows `done` with `err`=1, `timeout`=0 and status 0x00.
- R4: The data phase starts only when a sampled status byte has bit 7 (busy) clear and bit 3 (data request) set.
- R5: After each command byte, bit 0 (error) and bit 5 (device fault) are ignored in the first four status reads. If either bit is set in any later read, the sequence stops with `err`=1, `timeout`=0 and that status byte, and no further bus write follows.
- R6: The data phase writes exactly 256 words to offset 0, in FIFO order. Each `fifo_pop` goes with the write of that same word, and `fifo_pop` is never high while `fifo_empty` is high.
- R7: Two data-word writes are never in adjacent cycles.
- R8: After the last data word, 0xE7 is written to offset 7. Status is then read until bit 7 is clear, and only then is `done` given with `err`=0 and that status byte.
- R9: If `poll_limit` consecutive status reads in one wait neither complete nor fail it, the sequence ends with `err`=1, `timeout`=1 and the last status byte. The read count is exactly `poll_limit`.
- R10: After reset, `req_ready` is 1 and `done`, `bus_wr`, `bus_rd` and `fifo_pop` are 0. `done` is high for one cycle only. `req_ready` is low from acceptance until after `done`.
- R11: `bus_wr` and `bus_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_drive | input | 1 | Drive select placed in drive/head bit 4 |
| req_lba | input | 32 | Requested block address; legal range 0..0x0FFFFFFF |
| poll_limit | input | LIMIT_W | Status reads allowed per wait before a timeout |
| fifo_data | input | 16 | Front word of the sector FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Removes the front FIFO word |
| bus_addr | output | 3 | Register offset on the drive bus |
| bus_wdata | output | 16 | Value written to the drive |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Status byte, valid the cycle after `bus_rd` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a failure (held) |
| timeout | output | 1 | Failure was a poll timeout (held) |
| final_status | output | 8 | Last status byte read, 0x00 on rejection (held) |

## Verification
A wrong task-file index or a wrong state shows at the ports at once. The next bus write then has the wrong offset or value, so the write scoreboard catches it within one cycle of the fault. Faults in the read counters take longer to appear: the read that ends a wait comes one poll early or late. The bench therefore counts status reads for each case and compares them with the scripted error position and with `poll_limit`. A miscounted word counter or gap flag shows as a missing or extra offset-0 write before the flush command, or as two adjacent data strobes. The bench runs one case with FIFO stalls so that the pacing is seen under back-pressure.

// File: rtl/ata_wr_pkg.sv
package ata_wr_pkg;

  // register offsets on the drive bus
  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_COUNT   = 3'd2;
  localparam logic [2:0] OFS_ADR_LO  = 3'd3;
  localparam logic [2:0] OFS_ADR_MID = 3'd4;
  localparam logic [2:0] OFS_ADR_HI  = 3'd5;
  localparam logic [2:0] OFS_SELECT  = 3'd6;
  localparam logic [2:0] OFS_CMDSTAT = 3'd7;

  localparam logic [7:0] OP_WRITE = 8'h30;
  localparam logic [7:0] OP_FLUSH = 8'hE7;

  // status byte bits
  localparam logic [7:0] SB_BUSY  = 8'h80;
  localparam logic [7:0] SB_FAULT = 8'h20;
  localparam logic [7:0] SB_DREQ  = 8'h08;
  localparam logic [7:0] SB_ERROR = 8'h01;

  typedef enum logic [1:0] {
    PV_WAIT,
    PV_READY,
    PV_FAULT,
    PV_TIMEOUT
  } poll_verdict_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TASKFILE,
    SQ_POLL_RD,
    SQ_POLL_WAIT,
    SQ_POLL_SAMPLE,
    SQ_DATA,
    SQ_FLUSH
  } seq_state_t;

endpackage

// File: rtl/ata_taskfile_sel.sv
module ata_taskfile_sel
  import ata_wr_pkg::*;
(
  input  logic [2:0]  idx,
  input  logic        drive,
  input  logic [27:0] lba,
  output logic [2:0]  ofs,
  output logic [7:0]  value
);

  always_comb begin
    unique case (idx)
      3'd0: begin ofs = OFS_SELECT;  value = {3'b111, drive, lba[27:24]}; end
      3'd1: begin ofs = OFS_COUNT;   value = 8'h01;                       end
      3'd2: begin ofs = OFS_ADR_LO;  value = lba[7:0];                    end
      3'd3: begin ofs = OFS_ADR_MID; value = lba[15:8];                   end
      3'd4: begin ofs = OFS_ADR_HI;  value = lba[23:16];                  end
      default: begin ofs = OFS_CMDSTAT; value = OP_WRITE;                 end
    endcase
  end

endmodule

// File: rtl/ata_poll_tracker.sv
module ata_poll_tracker
  import ata_wr_pkg::*;
#(
  parameter int IGNORE_READS = 4,
  parameter int LIMIT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               sample,
  input  logic [7:0]         status,
  input  logic               need_dreq,
  input  logic [LIMIT_W-1:0] limit,
  output poll_verdict_t      verdict
);

  localparam int SEEN_W = $clog2(IGNORE_READS + 1);

  logic [SEEN_W-1:0]  seen;
  logic [LIMIT_W-1:0] polls;
  logic               busy, dreq, bad, armed, finished, exhausted;

  always_comb begin
    busy      = (status & SB_BUSY) != 8'h00;
    dreq      = (status & SB_DREQ) != 8'h00;
    bad       = (status & (SB_ERROR | SB_FAULT)) != 8'h00;
    armed     = seen == SEEN_W'(IGNORE_READS);
    finished  = !busy && (!need_dreq || dreq);
    exhausted = ({1'b0, polls} + 1'b1) >= {1'b0, limit};
    if (!sample)           verdict = PV_WAIT;
    else if (armed && bad) verdict = PV_FAULT;
    else if (finished)     verdict = PV_READY;
    else if (exhausted)    verdict = PV_TIMEOUT;
    else                   verdict = PV_WAIT;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen  <= '0;
      polls <= '0;
    end else if (sample) begin
      if (!armed) seen <= seen + 1'b1;
      polls <= polls + 1'b1;
    end
  end

endmodule

// File: rtl/ata_word_pacer.sv
module ata_word_pacer #(
  parameter int WORDS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fifo_empty,
  output logic take,
  output logic last_take
);

  localparam int CNT_W = $clog2(WORDS);

  logic             active;
  logic             gap;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    take      = active && !gap && !fifo_empty;
    last_take = take && (cnt == CNT_W'(WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      gap    <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      gap    <= 1'b0;
      cnt    <= '0;
    end else begin
      gap <= take;
      if (take) cnt <= cnt + 1'b1;
      if (last_take) active <= 1'b0;
    end
  end

endmodule

// File: rtl/ata_wr_seq.sv
module ata_wr_seq
  import ata_wr_pkg::*;
#(
  parameter int LIMIT_W      = 16,
  parameter int WORDS        = 256,
  parameter int IGNORE_READS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_drive,
  input  logic [31:0]        req_lba,
  input  logic [LIMIT_W-1:0] poll_limit,
  input  logic [15:0]        fifo_data,
  input  logic               fifo_empty,
  output logic               fifo_pop,
  output logic [2:0]         bus_addr,
  output logic [15:0]        bus_wdata,
  output logic               bus_wr,
  output logic               bus_rd,
  input  logic [7:0]         bus_rdata,
  output logic               done,
  output logic               err,
  output logic               timeout,
  output logic [7:0]         final_status
);

  localparam logic [2:0] TF_LAST = 3'd5;

  seq_state_t    state;
  logic [2:0]    tf_idx;
  logic          drive_q;
  logic [27:0]   lba_q;
  logic          flush_phase;
  logic [2:0]    tf_ofs;
  logic [7:0]    tf_value;
  poll_verdict_t verdict;
  logic          poll_clear, poll_sample, take, last_take, data_start;

  ata_taskfile_sel u_tf (
    .idx   (tf_idx),
    .drive (drive_q),
    .lba   (lba_q),
    .ofs   (tf_ofs),
    .value (tf_value)
  );

  always_comb begin
    poll_clear  = (state == SQ_TASKFILE && tf_idx == TF_LAST) || (state == SQ_FLUSH);
    poll_sample = (state == SQ_POLL_SAMPLE);
    data_start  = poll_sample && (verdict == PV_READY) && !flush_phase;
    req_ready   = (state == SQ_IDLE) && !done;
    fifo_pop    = take;
  end

  ata_poll_tracker #(
    .IGNORE_READS (IGNORE_READS),
    .LIMIT_W      (LIMIT_W)
  ) u_poll (
    .clk       (clk),
    .rst       (rst),
    .clear     (poll_clear),
    .sample    (poll_sample),
    .status    (bus_rdata),
    .need_dreq (!flush_phase),
    .limit     (poll_limit),
    .verdict   (verdict)
  );

  ata_word_pacer #(
    .WORDS (WORDS)
  ) u_pace (
    .clk        (clk),
    .rst        (rst),
    .start      (data_start),
    .fifo_empty (fifo_empty),
    .take       (take),
    .last_take  (last_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_IDLE;
      tf_idx       <= '0;
      drive_q      <= 1'b0;
      lba_q        <= '0;
      flush_phase  <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      bus_wr       <= 1'b0;
      bus_rd       <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      timeout      <= 1'b0;
      final_status <= '0;
    end else begin
      bus_wr <= 1'b0;
      bus_rd <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (req_valid && req_ready) begin
            if (req_lba[31:28] != 4'h0) begin
              done         <= 1'b1;
              err          <= 1'b1;
              timeout      <= 1'b0;
              final_status <= 8'h00;
            end else begin
              drive_q     <= req_drive;
              lba_q       <= req_lba[27:0];
              tf_idx      <= '0;
              flush_phase <= 1'b0;
              state       <= SQ_TASKFILE;
            end
          end
        end
        SQ_TASKFILE: begin
          bus_wr    <= 1'b1;
          bus_addr  <= tf_ofs;
          bus_wdata <= {8'h00, tf_value};
          if (tf_idx == TF_LAST) state <= SQ_POLL_RD;
          else                   tf_idx <= tf_idx + 1'b1;
        end
        SQ_POLL_RD: begin
          bus_rd   <= 1'b1;
          bus_addr <= OFS_CMDSTAT;
          state    <= SQ_POLL_WAIT;
        end
        SQ_POLL_WAIT: state <= SQ_POLL_SAMPLE;
        SQ_POLL_SAMPLE: begin
          unique case (verdict)
            PV_READY: begin
              if (flush_phase) begin
                done         <= 1'b1;
                err          <= 1'b0;
                timeout      <= 1'b0;
                final_status <= bus_rdata;
                state        <= SQ_IDLE;
              end else begin
                state <= SQ_DATA;
              end
            end
            PV_FAULT: begin
              done         <= 1'b1;
              err          <= 1'b1;
              timeout      <= 1'b0;
              final_status <= bus_rdata;
              state        <= SQ_IDLE;
            end
            PV_TIMEOUT: begin
              done         <= 1'b1;
              err          <= 1'b1;
              timeout      <= 1'b1;
              final_status <= bus_rdata;
              state        <= SQ_IDLE;
            end
            default: state <= SQ_POLL_RD;
          endcase
        end
        SQ_DATA: begin
          if (take) begin
            bus_wr    <= 1'b1;
            bus_addr  <= OFS_DATA;
            bus_wdata <= fifo_data;
            if (last_take) state <= SQ_FLUSH;
          end
        end
        SQ_FLUSH: begin
          bus_wr      <= 1'b1;
          bus_addr    <= OFS_CMDSTAT;
          bus_wdata   <= {8'h00, OP_FLUSH};
          flush_phase <= 1'b1;
          state       <= SQ_POLL_RD;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ata_wr_seq_chk.sv
module ata_wr_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_lba,
  input logic        fifo_empty,
  input logic        fifo_pop,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        done,
  input logic        err,
  input logic        timeout,
  input logic [7:0]  final_status
);

  a_r11_wr_rd_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  a_r7_data_gap: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 3'd0) |=> !(bus_wr && bus_addr == 3'd0));

  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  a_r3_reject: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_lba[31:28] != 4'h0)
      |=> (done && err && !timeout && final_status == 8'h00 && !bus_wr && !bus_rd));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |-> !req_ready);

  a_r8_done_idle_drive: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (final_status[7] == 1'b0));

  a_r9_timeout_is_error: assert property (@(posedge clk) disable iff (rst)
    (done && timeout) |-> err);

endmodule

bind ata_wr_seq ata_wr_seq_chk u_chk (.*);

// File: tb/sim_ata_wr_seq.sv
`timescale 1ns/1ps
module sim_ata_wr_seq;

  localparam int LW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_drive = 1'b0;
  logic [31:0] req_lba = '0;
  logic [LW-1:0] poll_limit = 16'd100;
  logic [15:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata = '0;
  logic        done;
  logic        err;
  logic        timeout;
  logic [7:0]  final_status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_count = 0;
  int wr_count = 0;

  logic [18:0] exp_q[$];
  logic [15:0] fifo_q[$];
  logic [7:0]  stat_q[$];
  logic [7:0]  stat_default = 8'h58;
  logic        stall_en = 1'b0;
  logic [1:0]  stall_ph = '0;
  logic        prev_data_wr = 1'b0;

  ata_wr_seq #(.LIMIT_W(LW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_drive(req_drive), .req_lba(req_lba), .poll_limit(poll_limit),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .done(done), .err(err), .timeout(timeout),
    .final_status(final_status)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  // drive model: status returned the cycle after the read strobe
  always @(posedge clk) begin
    if (bus_rd) begin
      rd_count++;
      if (stat_q.size() > 0) bus_rdata <= stat_q.pop_front();
      else                   bus_rdata <= stat_default;
    end
  end

  // first-word-fall-through FIFO model with optional stalls
  always @(posedge clk) begin
    logic [1:0] ph;
    if (fifo_pop && fifo_q.size() > 0) void'(fifo_q.pop_front());
    ph = stall_ph + 2'd1;
    stall_ph <= ph;
    fifo_empty <= (fifo_q.size() == 0) || (stall_en && ph == 2'd3);
    fifo_data  <= (fifo_q.size() > 0) ? fifo_q[0] : 16'h0000;
  end

  // monitor: scoreboard of bus writes, gap and exclusivity
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_wr && bus_rd) check(1'b0, "R11 write and read together", 1, 0);
      if (bus_wr) begin
        wr_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R3/R5 unexpected bus write", {13'd0, bus_addr, bus_wdata}, 0);
        end else begin
          logic [18:0] e;
          e = exp_q.pop_front();
          check({bus_addr, bus_wdata} == e,
                (e[18:16] == 3'd0) ? "R6 data word" :
                (e[18:16] == 3'd6) ? "R1 drive/head byte" : "R2/R8 register write",
                {13'd0, bus_addr, bus_wdata}, {13'd0, e});
        end
      end
      if (bus_wr && bus_addr == 3'd0 && prev_data_wr)
        check(1'b0, "R7 adjacent data strobes", 1, 0);
      prev_data_wr <= bus_wr && bus_addr == 3'd0;
    end
  end

  task automatic run_case(input bit drv, input logic [31:0] lba, input logic [LW-1:0] lim,
                          input bit with_data, input bit exp_err, input bit exp_to,
                          input logic [7:0] exp_st, input int exp_reads, input string tag);
    int rd0;
    int wr0;
    int n;
    bit seen;
    rd0 = rd_count;
    wr0 = wr_count;
    poll_limit = lim;
    if (lba[31:28] == 4'h0) begin
      exp_q.push_back({3'd6, 8'h00, 3'b111, drv, lba[27:24]});
      exp_q.push_back({3'd2, 16'h0001});
      exp_q.push_back({3'd3, 8'h00, lba[7:0]});
      exp_q.push_back({3'd4, 8'h00, lba[15:8]});
      exp_q.push_back({3'd5, 8'h00, lba[23:16]});
      exp_q.push_back({3'd7, 16'h0030});
      if (with_data) begin
        for (int i = 0; i < 256; i++) begin
          logic [15:0] w;
          w = lba[15:0] ^ (16'h1357 * i[15:0]);
          fifo_q.push_back(w);
          exp_q.push_back({3'd0, w});
        end
        exp_q.push_back({3'd7, 16'h00E7});
      end
    end
    @(negedge clk);
    @(negedge clk);
    req_drive = drv;
    req_lba   = lba;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = done;
    if (!seen && lba[31:28] == 4'h0)
      check(req_ready == 1'b0, {"R10 ready low while busy ", tag}, req_ready, 0);
    n = 0;
    while (!seen && n < 20000) begin
      @(negedge clk);
      seen = done;
      n++;
    end
    check(seen, {"R8/R9 completion seen ", tag}, seen, 1);
    check(err == exp_err, {"R5/R8/R9 err flag ", tag}, err, exp_err);
    check(timeout == exp_to, {"R9 timeout flag ", tag}, timeout, exp_to);
    check(final_status == exp_st, {"R5/R8 final status ", tag}, final_status, exp_st);
    check(exp_q.size() == 0, {"R2/R6/R8 all expected writes made ", tag}, exp_q.size(), 0);
    if (exp_reads >= 0)
      check(rd_count - rd0 == exp_reads, {"R5/R9 status read count ", tag}, rd_count - rd0, exp_reads);
    if (lba[31:28] != 4'h0) begin
      check(wr_count == wr0, "R3 no bus write on reject", wr_count - wr0, 0);
      check(rd_count == rd0, "R3 no bus read on reject", rd_count - rd0, 0);
    end
    @(negedge clk);
    check(done == 1'b0, {"R10 done is one cycle ", tag}, done, 0);
    check(req_ready == 1'b1, {"R10 ready after done ", tag}, req_ready, 1);
    check(final_status == exp_st, {"R10 status held ", tag}, final_status, exp_st);
    exp_q.delete();
    fifo_q.delete();
    stat_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
    check(done == 1'b0, "R10 reset done", done, 0);
    check(bus_wr == 1'b0 && bus_rd == 1'b0, "R10 reset strobes", {bus_wr, bus_rd}, 0);
    check(fifo_pop == 1'b0, "R10 reset pop", fifo_pop, 0);

    // R4 R5: errors in reads 1-2 ignored, busy then data request
    stat_default = 8'h58;
    stat_q = '{8'h81, 8'hA1, 8'h80, 8'h58, 8'h80, 8'h50};
    run_case(1'b1, 32'h0ABC_DEF1, 16'd100, 1'b1, 1'b0, 1'b0, 8'h50, 6, "normal");

    // R1 boundary address, drive 0, FIFO stalls exercise R6 R7
    stall_en = 1'b1;
    stat_default = 8'h58;
    run_case(1'b0, 32'h0FFF_FFFF, 16'd100, 1'b1, 1'b0, 1'b0, 8'h58, 2, "max lba stalled");
    stall_en = 1'b0;

    // R3 out-of-range address
    run_case(1'b1, 32'h1000_0000, 16'd100, 1'b0, 1'b1, 1'b0, 8'h00, 0, "reject");

    // R5 error on fifth read after command
    stat_default = 8'h80;
    stat_q = '{8'h80, 8'h80, 8'h80, 8'h80, 8'h81};
    run_case(1'b0, 32'h0000_1234, 16'd100, 1'b0, 1'b1, 1'b0, 8'h81, 5, "error 5th");

    // R5 device fault after flush command
    stat_q = '{8'h58, 8'h80, 8'h80, 8'h80, 8'h80, 8'hA0};
    run_case(1'b1, 32'h0123_4567, 16'd100, 1'b1, 1'b1, 1'b0, 8'hA0, 6, "fault in flush");

    // R9 poll timeout
    stat_default = 8'h80;
    run_case(1'b0, 32'h0000_0042, 16'd5, 1'b0, 1'b1, 1'b1, 8'h80, 5, "timeout");

    // recovery with address zero
    stat_default = 8'h58;
    run_case(1'b0, 32'h0000_0000, 16'd100, 1'b1, 1'b0, 1'b0, 8'h58, 2, "lba zero");

    finish_run();
  end

endmodule